// File: doc/BRIEF.md
# Hierarchical 16-lane prefix-sum network

The block computes an inclusive running sum across sixteen parallel lanes of unsigned data. Each lane result is the sum of its own input and every lower-numbered input, truncated to the lane width. Lanes are grouped into four sets of four. Each set first forms its own local running sums with a two-level recursive-doubling network. The four set totals then feed a second four-input recursive-doubling scan. The resulting offsets are added back into every lane of sets one to three.

The network has five adder levels and uses 37 two-input adders. Registers sit after the per-set scans, after the root scan and at the output, so the three phases form a fixed three-stage pipeline. A new vector can enter on every clock. Each result carries a valid flag that trails the input flag by exactly three cycles.

Top module: `hier_prefix_scan`

## Requirements
- R1: Output lane i equals the sum of input lanes 0 through i, modulo 2^DATA_W, where lane i occupies bits [i*DATA_W +: DATA_W] of both data buses.
- R2: Lanes 0 to 3 of the output depend only on input lanes 0 to 3; no offset is added to them.
- R3: Output lane 15 equals the sum of all sixteen input lanes, modulo 2^DATA_W.
- R4: Every output lane in set g (lanes 4g to 4g+3, g = 1..3) equals its set-local running sum plus the totals of all sets below g.
- R5: Sums that exceed the lane width wrap around modulo 2^DATA_W and do not disturb neighbouring lanes.
- R6: out_valid_o is high in cycle t+3 exactly when in_valid_i was high in cycle t, and the matching result is on out_data_o in that same cycle.
- R7: Vectors presented on consecutive cycles each produce their own independent result on consecutive cycles, in order.
- R8: While rst_ni is low, out_valid_o is low and out_data_o is all zero.
- R9: Input data offered while in_valid_i is low is ignored: out_valid_o stays low for it and out_data_o keeps the last valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Marks in_data_i as a vector to scan |
| in_data_i | input | 16*DATA_W | Sixteen input lanes, lane 0 in the low bits |
| out_valid_o | output | 1 | Marks out_data_o as a new result |
| out_data_o | output | 16*DATA_W | Sixteen inclusive running sums, lane 0 in the low bits |

## Verification
The hardest case to reach from the ports is a carry into the offset path that must reach only the higher sets: a wrong offset index or a missing exclusive shift shows only when the set totals differ from one another and from zero. The stimulus therefore includes vectors where a single set is non-zero and vectors near full scale that wrap. Bubbles carrying garbage data are interleaved with back-to-back bursts, so that the pipeline holds results from different vectors in each stage at the same time.

// File: rtl/hps_pkg.sv
package hps_pkg;
  localparam int unsigned GRP_LANES = 4;
  localparam int unsigned N_GRPS    = 4;
  localparam int unsigned N_LANES   = GRP_LANES * N_GRPS;
endpackage

// File: rtl/hps_ks_scan.sv
module hps_ks_scan #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 16
) (
  input  logic [N*W-1:0] x_i,
  output logic [N*W-1:0] y_o
);
  localparam int unsigned LVLS = $clog2(N);

  logic [W-1:0] lvl [LVLS+1][N];

  for (genvar k = 0; k < N; k++) begin : g_in
    assign lvl[0][k] = x_i[k*W +: W];
    assign y_o[k*W +: W] = lvl[LVLS][k];
  end

  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    for (genvar k = 0; k < N; k++) begin : g_lane
      if (k >= (1 << l)) begin : g_add
        assign lvl[l+1][k] = lvl[l][k] + lvl[l][k - (1 << l)];
      end else begin : g_pass
        assign lvl[l+1][k] = lvl[l][k];
      end
    end
  end
endmodule

// File: rtl/hps_fan.sv
module hps_fan #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 16
) (
  input  logic [N*W-1:0] x_i,
  input  logic [W-1:0]   ofs_i,
  output logic [N*W-1:0] y_o
);
  for (genvar k = 0; k < N; k++) begin : g_lane
    assign y_o[k*W +: W] = x_i[k*W +: W] + ofs_i;
  end
endmodule

// File: rtl/hier_prefix_scan.sv
module hier_prefix_scan
  import hps_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      in_valid_i,
  input  logic [N_LANES*DATA_W-1:0] in_data_i,
  output logic                      out_valid_o,
  output logic [N_LANES*DATA_W-1:0] out_data_o
);
  localparam int unsigned GW  = GRP_LANES * DATA_W;
  localparam int unsigned VW  = N_LANES * DATA_W;
  localparam int unsigned RW  = N_GRPS * DATA_W;

  // upsweep: per-set scans
  logic [VW-1:0] grp_scan;
  for (genvar g = 0; g < N_GRPS; g++) begin : g_grp
    hps_ks_scan #(.N(GRP_LANES), .W(DATA_W)) u_scan (
      .x_i(in_data_i[g*GW +: GW]),
      .y_o(grp_scan[g*GW +: GW])
    );
  end

  logic          s1_valid;
  logic [VW-1:0] s1_data;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_data  <= '0;
    end else begin
      s1_valid <= in_valid_i;
      if (in_valid_i) s1_data <= grp_scan;
    end
  end

  // root: scan of set totals
  logic [RW-1:0] totals, root_sum, ofs;
  for (genvar g = 0; g < N_GRPS; g++) begin : g_tot
    assign totals[g*DATA_W +: DATA_W] = s1_data[(g*GRP_LANES + GRP_LANES - 1)*DATA_W +: DATA_W];
    if (g == 0) begin : g_zero
      assign ofs[g*DATA_W +: DATA_W] = '0;
    end else begin : g_excl
      assign ofs[g*DATA_W +: DATA_W] = root_sum[(g-1)*DATA_W +: DATA_W];
    end
  end

  hps_ks_scan #(.N(N_GRPS), .W(DATA_W)) u_root (
    .x_i(totals),
    .y_o(root_sum)
  );

  logic          s2_valid;
  logic [VW-1:0] s2_data;
  logic [RW-1:0] s2_ofs;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_valid <= 1'b0;
      s2_data  <= '0;
      s2_ofs   <= '0;
    end else begin
      s2_valid <= s1_valid;
      if (s1_valid) begin
        s2_data <= s1_data;
        s2_ofs  <= ofs;
      end
    end
  end

  // downsweep: fan offsets into sets 1..N_GRPS-1
  logic [VW-1:0] fanned;
  for (genvar g = 0; g < N_GRPS; g++) begin : g_fan
    if (g == 0) begin : g_keep
      assign fanned[g*GW +: GW] = s2_data[g*GW +: GW];
    end else begin : g_add
      hps_fan #(.N(GRP_LANES), .W(DATA_W)) u_fan (
        .x_i  (s2_data[g*GW +: GW]),
        .ofs_i(s2_ofs[g*DATA_W +: DATA_W]),
        .y_o  (fanned[g*GW +: GW])
      );
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= s2_valid;
      if (s2_valid) out_data_o <= fanned;
    end
  end

  // checks relating ports across the pipeline
  logic [2:0]        up_cnt;
  logic [DATA_W-1:0] in_total;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          up_cnt <= '0;
    else if (up_cnt != 4) up_cnt <= up_cnt + 3'd1;
  end

  always_comb begin
    in_total = '0;
    for (int i = 0; i < N_LANES; i++) in_total = in_total + in_data_i[i*DATA_W +: DATA_W];
  end

  a_r6_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_cnt == 4) |-> (out_valid_o == $past(in_valid_i, 3)));

  a_r2_lane0_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_cnt == 4 && out_valid_o) |-> (out_data_o[DATA_W-1:0] == $past(in_data_i[DATA_W-1:0], 3)));

  a_r3_last_lane_total: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_cnt == 4 && out_valid_o) |-> (out_data_o[VW-1 -: DATA_W] == $past(in_total, 3)));

  a_r9_hold_on_bubble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_cnt == 4 && !out_valid_o) |-> $stable(out_data_o));
endmodule

// File: tb/hier_prefix_scan_test.sv
`timescale 1ns/1ps
module hier_prefix_scan_test;
  localparam int unsigned W  = 16;
  localparam int unsigned NL = 16;
  localparam int unsigned VW = NL * W;

  typedef struct {
    logic [VW-1:0] v;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [VW-1:0] in_data = '0;
  logic          out_valid;
  logic [VW-1:0] out_data;

  int total = 0;
  int bad = 0;
  item_t q[$];
  logic [2:0]    vpipe = '0;
  logic          have_last = 1'b0;
  logic [VW-1:0] last_res = '0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  hier_prefix_scan #(.DATA_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_data_o(out_data)
  );

  function automatic logic [VW-1:0] ref_scan(input logic [VW-1:0] x);
    logic [W-1:0] acc;
    logic [VW-1:0] r;
    acc = '0;
    r = '0;
    for (int i = 0; i < NL; i++) begin
      acc = acc + x[i*W +: W];
      r[i*W +: W] = acc;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [VW-1:0] v, input string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = v;
    it.v   = ref_scan(v);
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic bubble(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = {8{$urandom()}};
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) vpipe <= '0;
    else        vpipe <= {vpipe[1:0], in_valid};
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (out_valid !== vpipe[2]) begin
        bad++;
        $display("FAIL R6 valid act=%b exp=%b", out_valid, vpipe[2]);
      end
      if (out_valid === 1'b1) begin
        if (q.size() == 0) begin
          total++; bad++;
          $display("FAIL R6 unexpected result act=%h exp=none", out_data);
        end else begin
          item_t it;
          it = q.pop_front();
          check(it.tag, out_data, it.v);
          last_res  = it.v;
          have_last = 1'b1;
        end
      end else if (have_last) begin
        check("R9 hold", out_data, last_res);
      end
    end
  end

  task automatic finish_run;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [VW-1:0] v;
    in_data = {8{32'hdead_beef}};
    repeat (3) @(negedge clk);
    // R8: reset state while reset is held
    check("R8 data", out_data, '0);
    check("R8 valid", {{(VW-1){1'b0}}, out_valid}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    bubble(2);

    // R1: all ones, incrementing lanes
    for (int i = 0; i < NL; i++) v[i*W +: W] = 16'd1;
    send(v, "R1 ones");
    for (int i = 0; i < NL; i++) v[i*W +: W] = W'(i + 1);
    send(v, "R1 ramp");
    bubble(4);

    // R2: only set 0 non-zero, and set 0 zero with others non-zero
    v = '0;
    for (int i = 0; i < 4; i++) v[i*W +: W] = W'(10 * (i + 1));
    send(v, "R2 set0 only");
    v = '0;
    for (int i = 4; i < NL; i++) v[i*W +: W] = 16'h0101;
    send(v, "R2 set0 zero");
    bubble(3);

    // R4: single set non-zero, distinct totals per set
    for (int g = 1; g < 4; g++) begin
      v = '0;
      for (int k = 0; k < 4; k++) v[(4*g + k)*W +: W] = W'(g * 100 + k);
      send(v, "R4 single set");
    end
    v = '0;
    for (int g = 0; g < 4; g++) v[(4*g + 3)*W +: W] = W'(1 << (4*g));
    send(v, "R4 set tops");
    bubble(4);

    // R3 and R5: full scale wraps
    for (int i = 0; i < NL; i++) v[i*W +: W] = 16'hffff;
    send(v, "R3 all max");
    for (int i = 0; i < NL; i++) v[i*W +: W] = 16'h8000 + W'(i);
    send(v, "R5 wrap");
    v = '0;
    v[0 +: W] = 16'hffff;
    v[1*W +: W] = 16'd1;
    send(v, "R5 wrap no spill");
    bubble(4);

    // R7: back-to-back random burst
    for (int n = 0; n < 24; n++) begin
      v = {8{$urandom()}};
      send(v, "R7 burst");
    end
    // R9: garbage during bubbles, then mixed traffic
    bubble(5);
    for (int n = 0; n < 20; n++) begin
      v = {8{$urandom()}};
      send(v, "R1 mixed");
      if (n % 3 == 0) bubble(1 + n % 2);
    end
    bubble(8);
    if (q.size() != 0) begin
      total++; bad++;
      $display("FAIL R7 pending act=%0d exp=0", q.size());
    end
    finish_run();
  end
endmodule